// File: doc/BRIEF.md
# EEPROM Random-Read Command Sequencer

This block turns a single user request into the full command sequence needed to fetch one byte from a serial EEPROM that uses two address bytes. It does not produce bus waveforms itself. Instead it drives a byte-level bus engine through a request/done handshake. The commands are start, repeated start, stop, write a byte, and read a byte with a chosen acknowledge level. For each write, the engine returns whether the slave acknowledged it.

A transfer begins when `go` is sampled high while the sequencer is idle. The device select and memory address are captured at that moment. The sequencer then runs through a dummy-write address phase, a repeated start, a read-direction control byte and a single read answered with NACK, and closes with a stop. Once the stop completes, the received byte is presented with a one-cycle valid pulse. If any acknowledge is missing, the sequencer goes straight to stop, raises the error flag instead of the valid pulse, and returns to idle.

States and transitions:
- IDLE goes to START on `go`.
- START goes to CTRL_WR.
- CTRL_WR goes to ADDR on ACK and to STOP on NACK.
- ADDR loops once per address byte, from the most significant byte down. After the last byte it goes to RESTART on ACK. It goes to STOP on NACK.
- RESTART goes to CTRL_RD.
- CTRL_RD goes to READ on ACK and to STOP on NACK.
- READ goes to STOP.
- STOP goes to IDLE.

Every state except IDLE issues exactly one command and then waits for the engine's done before it moves on.

Top module: `eeprom_rdseq`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `err` and `cmd_req` are all 0.
- R2: A transfer with all acknowledges present issues exactly eight commands in this order: start, write, write, write, repeated start, write, read, stop. The `cmd_op` codes are none=0, start=1, repeated start=2, stop=3, write=4 and read=5.
- R3: The first control byte is {4'b1010, dev_sel, 1'b0}. The control byte after the repeated start is {4'b1010, dev_sel, 1'b1}.
- R4: The two address writes carry `mem_addr[15:8]` first and `mem_addr[7:0]` second.
- R5: The read command is issued with `cmd_nack` = 1.
- R6: On a successful transfer, `rd_valid` is high for exactly one cycle. That cycle follows the cycle in which the stop's `eng_done` is seen. In that cycle `rd_data` equals the byte the engine returned for the read and `err` is 0.
- R7: If a write finishes with `eng_ack` = 0, the next and last command is stop. After that stop is done, `err` is 1 and no `rd_valid` pulse occurs. `err` stays 1 until the next transfer is accepted, which clears it.
- R8: A `go` while `busy` is high is ignored. Later changes of `dev_sel` and `mem_addr` do not alter the command bytes of the running transfer, and no second transfer follows.
- R9: `busy` is high from the cycle after `go` is accepted until the stop completes, and it is low in the `rd_valid` cycle. No command is requested while `busy` is low.
- R10: Each command is requested with a `cmd_req` pulse of exactly one cycle. No new request is made until the engine has answered the previous one with `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe, honoured only when idle |
| dev_sel | input | 3 | Device select bits placed in the control byte |
| mem_addr | input | 16 | EEPROM memory address |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds the byte read |
| rd_data | output | 8 | Latched read byte |
| err | output | 1 | Last transfer ended on a missing acknowledge |
| cmd_req | output | 1 | One-cycle command request to the engine |
| cmd_op | output | 3 | Command code (encoding in R2) |
| cmd_wdata | output | 8 | Byte to send for a write command |
| cmd_nack | output | 1 | Acknowledge level for a read: 1 sends NACK |
| eng_done | input | 1 | Engine finished the current command |
| eng_ack | input | 1 | Slave acknowledged the write (valid with `eng_done`) |
| eng_rdata | input | 8 | Byte received by a read (valid with `eng_done`) |

## Verification
A wrong state transition shows up on the command port at the very next request. That request carries an unexpected opcode or byte, or it comes one command too early or too late. A slave model that logs every request catches it within one command of the fault. A lost issued flag shows up within a cycle as a doubled or missing `cmd_req` pulse. A wrong failure flag or a wrong result latch shows up only in the cycle after the stop completes, as a misplaced `rd_valid`, a wrong `err` or a wrong `rd_data`. The bench therefore checks the closing pulse on both successful and aborted transfers.

// File: rtl/eeprom_rdseq_pkg.sv
package eeprom_rdseq_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_START   = 3'd1,
        OP_RESTART = 3'd2,
        OP_STOP    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_READ    = 3'd5
    } bus_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_CTRL_WR,
        ST_ADDR,
        ST_RESTART,
        ST_CTRL_RD,
        ST_READ,
        ST_STOP
    } seq_state_e;

    typedef enum logic [1:0] {
        TX_NONE,
        TX_CTRL_WR,
        TX_CTRL_RD,
        TX_ADDR
    } tx_sel_e;

endpackage

// File: rtl/eeprom_rdseq_fsm.sv
module eeprom_rdseq_fsm
    import eeprom_rdseq_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int IDX_W      = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             eng_done,
    input  logic             eng_ack,
    output logic             accept,
    output logic             busy,
    output logic             cmd_req,
    output bus_op_e          cmd_op,
    output logic             cmd_nack,
    output tx_sel_e          tx_sel,
    output logic [IDX_W-1:0] byte_idx,
    output logic             rd_capture,
    output logic             finish,
    output logic             failed
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

    seq_state_e       state_q, state_n;
    logic             issued_q, issued_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic             fail_q, fail_n;
    logic             step;

    // Step: the command issued in this state has been answered by the engine
    assign step = issued_q && eng_done;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            issued_q <= 1'b0;
            idx_q    <= '0;
            fail_q   <= 1'b0;
        end else begin
            state_q  <= state_n;
            issued_q <= issued_n;
            idx_q    <= idx_n;
            fail_q   <= fail_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n  = state_q;
        idx_n    = idx_q;
        fail_n   = fail_q;
        issued_n = issued_q;
        if (state_q != ST_IDLE) begin
            if (!issued_q)
                issued_n = 1'b1;
            else if (eng_done)
                issued_n = 1'b0;
        end
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_n  = ST_START;
                    issued_n = 1'b0;
                    fail_n   = 1'b0;
                end
            end
            ST_START: begin
                if (step) state_n = ST_CTRL_WR;
            end
            ST_CTRL_WR: begin
                if (step) begin
                    if (eng_ack) begin
                        state_n = ST_ADDR;
                        idx_n   = LAST_IDX;
                    end else begin
                        state_n = ST_STOP;
                        fail_n  = 1'b1;
                    end
                end
            end
            ST_ADDR: begin
                if (step) begin
                    if (!eng_ack) begin
                        state_n = ST_STOP;
                        fail_n  = 1'b1;
                    end else if (idx_q == '0) begin
                        state_n = ST_RESTART;
                    end else begin
                        idx_n = idx_q - 1'b1;
                    end
                end
            end
            ST_RESTART: begin
                if (step) state_n = ST_CTRL_RD;
            end
            ST_CTRL_RD: begin
                if (step) begin
                    if (eng_ack) begin
                        state_n = ST_READ;
                    end else begin
                        state_n = ST_STOP;
                        fail_n  = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (step) state_n = ST_STOP;
            end
            ST_STOP: begin
                if (step) state_n = ST_IDLE;
            end
            default: begin
                state_n  = ST_IDLE;
                issued_n = 1'b0;
            end
        endcase
    end

    // Output logic
    always_comb begin
        cmd_op   = OP_NONE;
        tx_sel   = TX_NONE;
        cmd_nack = 1'b0;
        unique case (state_q)
            ST_IDLE:    cmd_op = OP_NONE;
            ST_START:   cmd_op = OP_START;
            ST_CTRL_WR: begin
                cmd_op = OP_WRITE;
                tx_sel = TX_CTRL_WR;
            end
            ST_ADDR: begin
                cmd_op = OP_WRITE;
                tx_sel = TX_ADDR;
            end
            ST_RESTART: cmd_op = OP_RESTART;
            ST_CTRL_RD: begin
                cmd_op = OP_WRITE;
                tx_sel = TX_CTRL_RD;
            end
            ST_READ: begin
                cmd_op   = OP_READ;
                cmd_nack = 1'b1;
            end
            ST_STOP:    cmd_op = OP_STOP;
            default:    cmd_op = OP_NONE;
        endcase
    end

    assign accept     = (state_q == ST_IDLE) && go;
    assign busy       = (state_q != ST_IDLE);
    assign cmd_req    = busy && !issued_q;
    assign byte_idx   = idx_q;
    assign rd_capture = (state_q == ST_READ) && step;
    assign finish     = (state_q == ST_STOP) && step;
    assign failed     = fail_q;

endmodule

// File: rtl/eeprom_rdseq_txmux.sv
module eeprom_rdseq_txmux
    import eeprom_rdseq_pkg::*;
#(
    parameter int                 DEV_W      = 3,
    parameter int                 ADDR_W     = 16,
    parameter int                 ADDR_BYTES = 2,
    parameter int                 IDX_W      = 1,
    parameter logic [6-DEV_W:0]   CTRL_ID    = 'b1010
) (
    input  tx_sel_e          tx_sel,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [DEV_W-1:0] dev_q,
    input  logic [ADDR_W-1:0] addr_q,
    output logic [7:0]       wdata
);

    logic [7:0] addr_byte [ADDR_BYTES];

    // Split the captured address into bytes; index 0 is the least significant
    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_addr_byte
        assign addr_byte[b] = addr_q[b*8 +: 8];
    end

    always_comb begin
        unique case (tx_sel)
            TX_CTRL_WR: wdata = {CTRL_ID, dev_q, 1'b0};
            TX_CTRL_RD: wdata = {CTRL_ID, dev_q, 1'b1};
            TX_ADDR:    wdata = addr_byte[byte_idx];
            default:    wdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/eeprom_rdseq_regs.sv
module eeprom_rdseq_regs #(
    parameter int DEV_W  = 3,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DEV_W-1:0]  dev_sel,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              rd_capture,
    input  logic [7:0]        eng_rdata,
    input  logic              finish,
    input  logic              failed,
    output logic [DEV_W-1:0]  dev_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              err
);

    // Request arguments, frozen for the whole transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q  <= '0;
            addr_q <= '0;
        end else if (accept) begin
            dev_q  <= dev_sel;
            addr_q <= mem_addr;
        end
    end

    // Result byte and closing flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            err      <= 1'b0;
        end else begin
            if (rd_capture)
                rd_data <= eng_rdata;
            rd_valid <= finish && !failed;
            if (accept)
                err <= 1'b0;
            else if (finish && failed)
                err <= 1'b1;
        end
    end

endmodule

// File: rtl/eeprom_rdseq.sv
module eeprom_rdseq
    import eeprom_rdseq_pkg::*;
#(
    parameter int DEV_W  = 3,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DEV_W-1:0]  dev_sel,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              err,
    output logic              cmd_req,
    output logic [2:0]        cmd_op,
    output logic [7:0]        cmd_wdata,
    output logic              cmd_nack,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic [7:0]        eng_rdata
);

    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int IDX_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    logic              accept;
    bus_op_e           op;
    tx_sel_e           tx_sel;
    logic [IDX_W-1:0]  byte_idx;
    logic              rd_capture;
    logic              finish;
    logic              failed;
    logic [DEV_W-1:0]  dev_q;
    logic [ADDR_W-1:0] addr_q;

    eeprom_rdseq_fsm #(
        .ADDR_BYTES (ADDR_BYTES),
        .IDX_W      (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .eng_done   (eng_done),
        .eng_ack    (eng_ack),
        .accept     (accept),
        .busy       (busy),
        .cmd_req    (cmd_req),
        .cmd_op     (op),
        .cmd_nack   (cmd_nack),
        .tx_sel     (tx_sel),
        .byte_idx   (byte_idx),
        .rd_capture (rd_capture),
        .finish     (finish),
        .failed     (failed)
    );

    eeprom_rdseq_txmux #(
        .DEV_W      (DEV_W),
        .ADDR_W     (ADDR_W),
        .ADDR_BYTES (ADDR_BYTES),
        .IDX_W      (IDX_W)
    ) u_txmux (
        .tx_sel   (tx_sel),
        .byte_idx (byte_idx),
        .dev_q    (dev_q),
        .addr_q   (addr_q),
        .wdata    (cmd_wdata)
    );

    eeprom_rdseq_regs #(
        .DEV_W  (DEV_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .dev_sel    (dev_sel),
        .mem_addr   (mem_addr),
        .rd_capture (rd_capture),
        .eng_rdata  (eng_rdata),
        .finish     (finish),
        .failed     (failed),
        .dev_q      (dev_q),
        .addr_q     (addr_q),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .err        (err)
    );

    assign cmd_op = op;

endmodule

// File: rtl/eeprom_rdseq_chk.sv
module eeprom_rdseq_chk
    import eeprom_rdseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       go,
    input logic       busy,
    input logic       rd_valid,
    input logic       err,
    input logic       cmd_req,
    input logic [2:0] cmd_op,
    input logic [7:0] cmd_wdata,
    input logic       cmd_nack,
    input logic       eng_done,
    input logic       eng_ack
);

    logic [2:0] last_op;
    logic       miss_q;

    // Last command requested in the current transfer, and a missed-ACK marker
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            last_op <= OP_NONE;
            miss_q  <= 1'b0;
        end else begin
            if (cmd_req)
                last_op <= cmd_op;
            if (eng_done && !eng_ack && last_op == OP_WRITE)
                miss_q <= 1'b1;
        end
    end

    a_r1_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_req);

    a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && last_op == OP_NONE) |-> cmd_op == OP_START);

    a_r2_stop_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && last_op == OP_READ) |-> cmd_op == OP_STOP);

    a_r3_ctrl_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_op == OP_WRITE && (last_op == OP_START || last_op == OP_RESTART))
        |-> (cmd_wdata[7:4] == 4'b1010 && cmd_wdata[0] == (last_op == OP_RESTART)));

    a_r5_read_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_op == OP_READ) |-> cmd_nack);

    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r6_valid_closes: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!busy && !err && $past(busy)));

    a_r7_stop_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && miss_q) |-> cmd_op == OP_STOP);

    a_r9_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy);

    a_r10_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |=> !cmd_req);

endmodule

bind eeprom_rdseq eeprom_rdseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .err       (err),
    .cmd_req   (cmd_req),
    .cmd_op    (cmd_op),
    .cmd_wdata (cmd_wdata),
    .cmd_nack  (cmd_nack),
    .eng_done  (eng_done),
    .eng_ack   (eng_ack)
);

// File: tb/eeprom_rdseq_bench.sv
module eeprom_rdseq_bench;
    import eeprom_rdseq_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [2:0]  dev_sel = '0;
    logic [15:0] mem_addr = '0;
    logic        busy, rd_valid, err, cmd_req, cmd_nack;
    logic [7:0]  rd_data, cmd_wdata;
    logic [2:0]  cmd_op;
    logic        eng_done, eng_ack;
    logic [7:0]  eng_rdata;

    eeprom_rdseq u_eeprom_rdseq (
        .clk (clk), .rst_n (rst_n), .go (go), .dev_sel (dev_sel), .mem_addr (mem_addr),
        .busy (busy), .rd_valid (rd_valid), .rd_data (rd_data), .err (err),
        .cmd_req (cmd_req), .cmd_op (cmd_op), .cmd_wdata (cmd_wdata), .cmd_nack (cmd_nack),
        .eng_done (eng_done), .eng_ack (eng_ack), .eng_rdata (eng_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Slave model state
    int         lat = 1;
    int         fail_at = -1;
    logic [7:0] rd_byte = 8'h00;
    logic [2:0] log_op   [16];
    logic [7:0] log_dat  [16];
    logic       log_nack [16];
    int         n_cmd = 0;
    int         wr_cnt = 0;
    int         proto_err = 0;
    int         valid_cnt = 0;

    // Transfer results
    logic       end_valid, end_err, after_valid;
    logic [7:0] end_data;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Byte-level engine / slave model
    initial begin
        eng_done = 1'b0;
        eng_ack = 1'b0;
        eng_rdata = 8'h00;
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            eng_ack = 1'b0;
            if (rst_n && cmd_req) begin
                logic ack_v;
                if (n_cmd < 16) begin
                    log_op[n_cmd]   = cmd_op;
                    log_dat[n_cmd]  = cmd_wdata;
                    log_nack[n_cmd] = cmd_nack;
                end
                n_cmd++;
                ack_v = 1'b1;
                if (cmd_op == OP_WRITE) begin
                    ack_v = (wr_cnt != fail_at);
                    wr_cnt++;
                end
                repeat (lat) begin
                    @(negedge clk);
                    if (cmd_req) proto_err++;
                end
                eng_done = 1'b1;
                eng_ack = ack_v;
                eng_rdata = rd_byte;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_valid) valid_cnt++;
        end
    end

    task automatic run_xfer(input logic [2:0] dev, input logic [15:0] addr, input logic [7:0] data,
                            input int l, input int f, input int poke);
        int cyc;
        n_cmd = 0; wr_cnt = 0; proto_err = 0;
        lat = l; fail_at = f; rd_byte = data;
        @(negedge clk);
        dev_sel = dev; mem_addr = addr; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(busy == 1'b1, "R9 busy after go", busy, 1);
        cyc = 0;
        while (busy && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (poke != 0 && cyc == poke) begin
                go = 1'b1; dev_sel = ~dev; mem_addr = ~addr;
            end else begin
                go = 1'b0;
            end
        end
        go = 1'b0;
        chk(cyc < 400, "R9 transfer ends", cyc, 0);
        end_valid = rd_valid; end_err = err; end_data = rd_data;
        @(negedge clk);
        after_valid = rd_valid;
        chk(proto_err == 0, "R10 single request per command", proto_err, 0);
    endtask

    task automatic exp_cmd(input int i, input logic [2:0] op, input logic [7:0] d, input string tag);
        chk(log_op[i] == op, tag, log_op[i], op);
        if (op == OP_WRITE) chk(log_dat[i] == d, tag, log_dat[i], d);
    endtask

    task automatic t_success(input logic [2:0] dev, input logic [15:0] addr, input logic [7:0] data,
                             input int l, input int poke);
        int v0 = valid_cnt;
        run_xfer(dev, addr, data, l, -1, poke);
        chk(n_cmd == 8, "R2 command count", n_cmd, 8);
        exp_cmd(0, OP_START,   8'h00, "R2 cmd0 start");
        exp_cmd(1, OP_WRITE,   {4'b1010, dev, 1'b0}, "R3 write control byte");
        exp_cmd(2, OP_WRITE,   addr[15:8], "R4 address high byte");
        exp_cmd(3, OP_WRITE,   addr[7:0], "R4 address low byte");
        exp_cmd(4, OP_RESTART, 8'h00, "R2 repeated start");
        exp_cmd(5, OP_WRITE,   {4'b1010, dev, 1'b1}, "R3 read control byte");
        exp_cmd(6, OP_READ,    8'h00, "R2 read");
        chk(log_nack[6] == 1'b1, "R5 read nack", log_nack[6], 1);
        exp_cmd(7, OP_STOP,    8'h00, "R2 stop");
        chk(end_valid == 1'b1, "R6 valid after stop", end_valid, 1);
        chk(end_data == data, "R6 read data", end_data, data);
        chk(end_err == 1'b0, "R6 no error", end_err, 0);
        chk(after_valid == 1'b0, "R6 valid one cycle", after_valid, 0);
        chk(valid_cnt - v0 == 1, "R6 one pulse", valid_cnt - v0, 1);
        if (poke != 0) begin
            go = 1'b0;
            repeat (10) @(negedge clk);
            chk(n_cmd == 8, "R8 no second transfer", n_cmd, 8);
            chk(busy == 1'b0, "R8 idle after ignored go", busy, 0);
        end
    endtask

    task automatic t_fail(input int f);
        int v0 = valid_cnt;
        int en = (f < 3) ? f + 3 : 7;
        run_xfer(3'b011, 16'hBEEF, 8'h77, 2, f, 0);
        chk(n_cmd == en, "R7 command count on nack", n_cmd, en);
        chk(log_op[en-1] == OP_STOP, "R7 stop after nack", log_op[en-1], OP_STOP);
        chk(log_op[en-2] == OP_WRITE, "R7 nacked write precedes stop", log_op[en-2], OP_WRITE);
        chk(end_err == 1'b1, "R7 error flag", end_err, 1);
        chk(end_valid == 1'b0, "R7 no valid", end_valid, 0);
        chk(valid_cnt == v0, "R7 no valid pulse", valid_cnt - v0, 0);
        chk(err == 1'b1, "R7 error held", err, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy reset", busy, 0);
        chk(rd_valid == 1'b0, "R1 valid reset", rd_valid, 0);
        chk(err == 1'b0, "R1 err reset", err, 0);
        chk(cmd_req == 1'b0, "R1 req reset", cmd_req, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cmd_req == 1'b0, "R9 no request while idle", cmd_req, 0);

        t_success(3'b101, 16'h3C7A, 8'hA5, 1, 0);
        t_success(3'b000, 16'h0001, 8'h5C, 3, 0);
        t_fail(0);
        t_fail(1);
        t_fail(2);
        t_fail(3);
        t_success(3'b110, 16'hF00D, 8'h3E, 1, 0);
        t_success(3'b010, 16'h1234, 8'hC3, 2, 5);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule